// File: doc/BRIEF.md
# Handshake Strobe Control Line Generator

This block drives one configurable peripheral control line of a parallel port whenever its three-bit mode field selects output operation. In strobe mode it pulls the line low in response to a processor access of the port data register and releases it again either when the peripheral answers with an acknowledge edge or after a later bus cycle in which the port was not selected. In fixed mode the line simply carries a level that software writes. When the mode field selects input, the driver is released and the line is left to other logic.

One parameter picks the port flavour. The read flavour (`SIDE_B = 0`) strobes on data reads and works on falling edges of the bus enable E. The write flavour (`SIDE_B = 1`) strobes on data writes and works on rising edges of E. E, the select state, the access pulse and the acknowledge pulse are all sampled on the system clock. Edges of E are found by comparing E with its value one clock earlier, so every change on the line appears one clock after the clock edge that sees its cause.

The mode field `ctl_mode` is decoded as follows. Bit 2 is the driver enable. Bit 1 picks fixed level (1) or strobe (0) while the driver is on. Bit 0 is the fixed level in fixed mode. In strobe mode, bit 0 picks the restore source: acknowledge (0) or deselected cycle (1).

Top module: `hsk_ctl_line`

## Requirements
- R1: While `rst_n` is low, `line_oe` is 0 (line configured as input) and `line_out` is 1.
- R2: `line_oe` equals `ctl_mode[2]` as sampled at the previous clock edge, so a 0 in bit 2 releases the driver one clock later.
- R3: With `ctl_mode[2:1] = 11`, `line_out` equals `ctl_mode[0]` as sampled at the previous clock edge.
- R4: When `ctl_mode[2:1]` becomes `10` from any other value, `line_out` is 1 one clock later, whatever the line held before.
- R5: In strobe mode, a `data_acc` pulse taken while the line is high and E is high arms a strobe. The line goes low one clock after the first following E edge of the flavour's kind: for the read flavour, a falling edge (so the same E pulse ends the access); for the write flavour, a rising edge (so the next E pulse).
- R6: In strobe mode with `ctl_mode[0] = 0`, a one-clock `ack_edge` pulse returns a low line to 1 one clock later. E activity alone does not release the line.
- R7: Read flavour, strobe mode with `ctl_mode[0] = 1`: a low line returns to 1 one clock after the first E falling edge at which `sel` is 0. An E falling edge with `sel` at 1 and `ack_edge` pulses leave the line low.
- R8: Write flavour, strobe mode with `ctl_mode[0] = 1`: a low line returns to 1 one clock after the first E rising edge that follows an E pulse whose falling edge saw `sel` at 0. `ack_edge` pulses leave it low.
- R9: A `data_acc` pulse that arrives while the line is low arms nothing. After the line is restored, no further low pulse follows from it.
- R10: While `ctl_mode[2]` is 0, `line_out` is held at 1 one clock after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_mode | input | 3 | Mode field: [2] driver on, [1] fixed/strobe, [0] level or restore source |
| e_strobe | input | 1 | Bus enable E, sampled on `clk` |
| sel | input | 1 | Port selected during the current E pulse |
| data_acc | input | 1 | One-clock pulse: data register read (read flavour) or write (write flavour) |
| ack_edge | input | 1 | One-clock pulse: active transition of the companion acknowledge input |
| line_out | output | 1 | Level driven on the control line |
| line_oe | output | 1 | Output enable of the control line driver |

## Verification
The bench builds the block twice from one stimulus: once with `SIDE_B = 0` and once with `SIDE_B = 1`. The same E pulses, access pulses and acknowledges therefore show the different edge each flavour strobes on, and the different deselected-cycle restore of each. Running both flavours side by side brings within reach the write flavour's two-pulse delay before restore. It also covers the case where an access during a low line is dropped by one flavour while the other has already consumed its armed strobe.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

   // Decoded upper two bits of the mode field
   typedef enum logic [1:0] {
      HSK_INPUT_L = 2'b00,
      HSK_INPUT_H = 2'b01,
      HSK_STROBE  = 2'b10,
      HSK_FIXED   = 2'b11
   } hsk_mode_e;

   localparam int unsigned HSK_SIDE_READ  = 0;
   localparam int unsigned HSK_SIDE_WRITE = 1;
   localparam int unsigned HSK_MODE_W     = 3;

   function automatic hsk_mode_e hsk_decode(input logic [HSK_MODE_W-1:0] f);
      return hsk_mode_e'(f[HSK_MODE_W-1:HSK_MODE_W-2]);
   endfunction

endpackage

// File: rtl/hsk_edge_sense.sv
// Finds E edges and derives the strobe edge and the deselected-cycle
// restore event for the chosen port flavour.
module hsk_edge_sense #(
   parameter int unsigned SIDE_B = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic e_strobe,
   input  logic sel,
   output logic strobe_edge,
   output logic desel_restore
);
   logic e_q;
   logic e_rise;
   logic e_fall;

   always_ff @(posedge clk) begin
      if (!rst_n) e_q <= 1'b0;
      else        e_q <= e_strobe;
   end

   assign e_rise = e_strobe & ~e_q;
   assign e_fall = e_q & ~e_strobe;

   if (SIDE_B == hsk_pkg::HSK_SIDE_READ) begin : g_read
      // strobe and restore both on the trailing edge of E
      assign strobe_edge   = e_fall;
      assign desel_restore = e_fall & ~sel;
   end else begin : g_write
      logic desel_seen;
      // remember a pulse that ended while deselected, consume on next rise
      always_ff @(posedge clk) begin
         if (!rst_n)                 desel_seen <= 1'b0;
         else if (e_rise)            desel_seen <= 1'b0;
         else if (e_fall && !sel)    desel_seen <= 1'b1;
      end
      assign strobe_edge   = e_rise;
      assign desel_restore = e_rise & desel_seen;
   end

endmodule

// File: rtl/hsk_access_arm.sv
// Holds a pending strobe request between the data access and the edge
// that turns it into a low level.
module hsk_access_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic data_acc,
   input  logic line_high,
   input  logic strobe_edge,
   output logic armed
);
   always_ff @(posedge clk) begin
      if (!rst_n)                    armed <= 1'b0;
      else if (!enable)              armed <= 1'b0;
      else if (strobe_edge)          armed <= 1'b0;
      else if (data_acc && line_high) armed <= 1'b1;
   end
endmodule

// File: rtl/hsk_ctl_line.sv
module hsk_ctl_line #(
   parameter int unsigned SIDE_B = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] ctl_mode,
   input  logic       e_strobe,
   input  logic       sel,
   input  logic       data_acc,
   input  logic       ack_edge,
   output logic       line_out,
   output logic       line_oe
);
   import hsk_pkg::*;

   localparam int unsigned EN_BIT  = HSK_MODE_W - 1;
   localparam int unsigned SRC_BIT = 0;

   if (SIDE_B != HSK_SIDE_READ && SIDE_B != HSK_SIDE_WRITE) begin : g_bad_side
      $error("hsk_ctl_line: SIDE_B must be 0 or 1");
   end

   hsk_mode_e mode;
   hsk_mode_e mode_q;
   logic      lvl;
   logic      oe_q;
   logic      strobe_run;
   logic      strobe_edge;
   logic      desel_restore;
   logic      armed;
   logic      go_low;
   logic      restore;

   assign mode       = hsk_decode(ctl_mode);
   assign strobe_run = (mode == HSK_STROBE) && (mode_q == HSK_STROBE);

   hsk_edge_sense #(.SIDE_B(SIDE_B)) u_edge (
      .clk           (clk),
      .rst_n         (rst_n),
      .e_strobe      (e_strobe),
      .sel           (sel),
      .strobe_edge   (strobe_edge),
      .desel_restore (desel_restore)
   );

   hsk_access_arm u_arm (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (strobe_run),
      .data_acc    (data_acc),
      .line_high   (lvl),
      .strobe_edge (strobe_edge),
      .armed       (armed)
   );

   assign go_low  = armed & strobe_edge;
   assign restore = ctl_mode[SRC_BIT] ? desel_restore : ack_edge;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl    <= 1'b1;
         oe_q   <= 1'b0;
         mode_q <= HSK_INPUT_L;
      end else begin
         oe_q   <= ctl_mode[EN_BIT];
         mode_q <= mode;
         unique case (mode)
            HSK_FIXED:  lvl <= ctl_mode[SRC_BIT];
            HSK_STROBE: begin
               if (mode_q != HSK_STROBE) lvl <= 1'b1;
               else if (go_low)          lvl <= 1'b0;
               else if (restore)         lvl <= 1'b1;
            end
            default:    lvl <= 1'b1;
         endcase
      end
   end

   assign line_out = lvl;
   assign line_oe  = oe_q;

endmodule

// File: rtl/hsk_ctl_line_chk.sv
module hsk_ctl_line_chk #(
   parameter int unsigned SIDE_B = 0
) (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] ctl_mode,
   input logic       e_strobe,
   input logic       line_out,
   input logic       line_oe
);
   logic       e_d;
   logic       ev_q;
   logic [1:0] mode_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_d    <= 1'b0;
         ev_q   <= 1'b0;
         mode_d <= 2'b00;
      end else begin
         e_d    <= e_strobe;
         ev_q   <= (SIDE_B != 0) ? (e_strobe & ~e_d) : (e_d & ~e_strobe);
         mode_d <= ctl_mode[2:1];
      end
   end

   // R2: driver released one clock after bit 2 is seen low
   a_r2_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_mode[2] |=> !line_oe);

   // R3: fixed mode carries bit 0
   a_r3_fixed_level: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_mode[2:1] == 2'b11) |=> (line_out == $past(ctl_mode[0])));

   // R4: entering strobe mode starts high
   a_r4_strobe_entry_high: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctl_mode[2:1] == 2'b10) && ($past(ctl_mode[2:1]) != 2'b10)) |=> line_out);

   // R10: level parked high while the driver is off
   a_r10_parked_high: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_mode[2] |=> line_out);

   // R5: in strobe mode the line only falls on the flavour's E edge
   a_r5_fall_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(line_out) && (mode_d == 2'b10)) |-> ev_q);

endmodule

bind hsk_ctl_line hsk_ctl_line_chk #(.SIDE_B(SIDE_B)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctl_mode (ctl_mode),
   .e_strobe (e_strobe),
   .line_out (line_out),
   .line_oe  (line_oe)
);

// File: tb/test_hsk_ctl_line.sv
module test_hsk_ctl_line;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [2:0] ctl;
   logic       e, sel, acc, ack;
   logic       a_out, a_oe, b_out, b_oe;
   int         checks = 0;
   int         errors = 0;

   always #2 clk = ~clk;

   hsk_ctl_line #(.SIDE_B(0)) i_hsk_ctl_line (
      .clk(clk), .rst_n(rst_n), .ctl_mode(ctl), .e_strobe(e), .sel(sel),
      .data_acc(acc), .ack_edge(ack), .line_out(a_out), .line_oe(a_oe));

   hsk_ctl_line #(.SIDE_B(1)) i_hsk_ctl_line_b (
      .clk(clk), .rst_n(rst_n), .ctl_mode(ctl), .e_strobe(e), .sel(sel),
      .data_acc(acc), .ack_edge(ack), .line_out(b_out), .line_oe(b_oe));

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic e_up(input logic s, input logic do_acc);
      @(negedge clk); e = 1'b1; sel = s;
      tick(2);
      if (do_acc) acc = 1'b1;
      tick(1);
      acc = 1'b0;
      tick(2);
   endtask

   task automatic e_down();
      @(negedge clk); e = 1'b0;
      tick(3);
   endtask

   task automatic pulse(input logic s, input logic do_acc);
      e_up(s, do_acc);
      e_down();
   endtask

   task automatic give_ack();
      @(negedge clk); ack = 1'b1;
      tick(1);
      ack = 1'b0;
      tick(1);
   endtask

   task automatic set_mode(input logic [2:0] m);
      @(negedge clk); ctl = m;
      tick(2);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; ctl = 3'b000; e = 1'b0; sel = 1'b0; acc = 1'b0; ack = 1'b0;
      tick(3);
      chk(a_oe, 1'b0, "R1 read oe in reset");
      chk(b_oe, 1'b0, "R1 write oe in reset");
      chk(a_out, 1'b1, "R1 read level in reset");
      chk(b_out, 1'b1, "R1 write level in reset");
      rst_n = 1'b1;
      tick(2);
   endtask

   task automatic t_input_mode();
      set_mode(3'b001);
      chk(a_oe, 1'b0, "R2 read oe off");
      chk(b_oe, 1'b0, "R2 write oe off");
      chk(a_out, 1'b1, "R10 read parked high");
      chk(b_out, 1'b1, "R10 write parked high");
   endtask

   task automatic t_fixed();
      set_mode(3'b110);
      chk(a_oe, 1'b1, "R2 read oe on");
      chk(a_out, 1'b0, "R3 read fixed low");
      chk(b_out, 1'b0, "R3 write fixed low");
      set_mode(3'b111);
      chk(a_out, 1'b1, "R3 read fixed high");
      chk(b_out, 1'b1, "R3 write fixed high");
      set_mode(3'b110);
      chk(a_out, 1'b0, "R3 read fixed low again");
      set_mode(3'b100);
      chk(a_out, 1'b1, "R4 read entry high");
      chk(b_out, 1'b1, "R4 write entry high");
      chk(b_oe, 1'b1, "R2 write oe on in strobe");
   endtask

   task automatic t_ack_restore();
      set_mode(3'b000);
      set_mode(3'b100);
      pulse(1'b1, 1'b1);
      chk(a_out, 1'b0, "R5 read low after E fall");
      chk(b_out, 1'b1, "R5 write still high after write pulse");
      e_up(1'b1, 1'b0);
      chk(b_out, 1'b0, "R5 write low at next E rise");
      e_down();
      chk(a_out, 1'b0, "R6 read held low without ack");
      chk(b_out, 1'b0, "R6 write held low without ack");
      give_ack();
      chk(a_out, 1'b1, "R6 read restored by ack");
      chk(b_out, 1'b1, "R6 write restored by ack");
      pulse(1'b1, 1'b0);
      chk(a_out, 1'b1, "R6 read stays high, no access");
      chk(b_out, 1'b1, "R6 write stays high, no access");
   endtask

   task automatic t_reaccess();
      set_mode(3'b000);
      set_mode(3'b100);
      pulse(1'b1, 1'b1);
      chk(a_out, 1'b0, "R9 read first strobe low");
      pulse(1'b1, 1'b1);
      chk(a_out, 1'b0, "R9 read held low on second read");
      chk(b_out, 1'b0, "R9 write low from first write");
      give_ack();
      chk(a_out, 1'b1, "R9 read restored");
      chk(b_out, 1'b1, "R9 write restored");
      e_up(1'b1, 1'b0);
      chk(b_out, 1'b1, "R9 write no second pulse");
      e_down();
      chk(a_out, 1'b1, "R9 read no second pulse");
   endtask

   task automatic t_e_restore();
      set_mode(3'b000);
      set_mode(3'b101);
      pulse(1'b1, 1'b1);
      chk(a_out, 1'b0, "R7 read low after E fall");
      give_ack();
      chk(a_out, 1'b0, "R7 read ignores ack");
      e_up(1'b1, 1'b0);
      chk(b_out, 1'b0, "R8 write low at E rise");
      e_down();
      chk(a_out, 1'b0, "R7 read held low after selected cycle");
      give_ack();
      chk(b_out, 1'b0, "R8 write ignores ack");
      e_up(1'b0, 1'b0);
      chk(b_out, 1'b0, "R8 write low at rise of deselected pulse");
      e_down();
      chk(a_out, 1'b1, "R7 read restored by deselected E fall");
      chk(b_out, 1'b0, "R8 write low until next rise");
      e_up(1'b1, 1'b0);
      chk(b_out, 1'b1, "R8 write restored at rise after deselected pulse");
      e_down();
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_input_mode();
      t_fixed();
      t_ack_restore();
      t_reaccess();
      t_e_restore();
      set_mode(3'b000);
      chk(a_oe, 1'b0, "R2 read oe released at end");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule